// File: doc/BRIEF.md
# Read Latency and Byte-Lane Mask Pipeline

This block sits between the column access of a synchronous memory core and its data pins. Read data that the core delivers alongside a read-valid flag is carried down a three-stage shift register, and the programmed read latency of two or three clocks picks which stage drives the 16-bit output word. Each of the two byte lanes has a mask input. On the read side the mask is delayed by two clocks and then gates that lane's output enable. On the write side the same mask gates that lane's core write strobe in the cycle it is applied.

The latency setting is a two-bit code. A new code is taken only while no read is in flight. A request for a different latency while reads are pending is refused and reported on an error output. The pad driver that turns the output word and the enables into tri-state pins lies outside this block.

Top module: `cl_read_pipe`

## Requirements
- R1: While reset is held, and in the first cycles after it, `dq_out` and `dq_oe` are zero and `lat_err` is low. The active latency after reset is three clocks.
- R2: A `cas_lat` code of 3 selects a latency of three clocks and any other code selects two. Read data sampled with `rd_vld` at clock edge n is on `dq_out` for sampling at edge n+L, where L is the active latency.
- R3: `dq_out` is all zeros in every cycle in which no read data has reached the selected stage.
- R4: `byte_mask[0]` governs lane 0 (`dq_out[7:0]`, `dq_oe[0]`) and `byte_mask[1]` governs lane 1 (`dq_out[15:8]`, `dq_oe[1]`). When read data is at the selected stage, `dq_oe[b]` is 1 exactly when `byte_mask[b]` was 0 at the edge two clocks earlier.
- R5: Both bits of `dq_oe` are 0 in any cycle without valid read data at the selected stage, whatever the masks are.
- R6: `core_wr_be[b]` equals `wr_vld` AND NOT `byte_mask[b]` in the same cycle, and `core_wr_data` equals `wr_data` in the same cycle.
- R7: A latency code is accepted at an edge where no read is sampled and none of the three stages holds a read. Reads sampled after that edge use the new latency.
- R8: If the code decodes to a latency other than the active one at an edge where a read is sampled or any stage holds a read, the active latency is kept and `lat_err` is high in the following cycle.
- R9: Reads on consecutive edges give data on consecutive cycles with no gap, at both latencies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised on release |
| rd_vld | input | 1 | Core read data valid this cycle |
| rd_data | input | 16 | Read word from the core |
| wr_vld | input | 1 | Write data valid this cycle |
| wr_data | input | 16 | Write word from the pins |
| byte_mask | input | 2 | Lane masks, bit 0 low byte, bit 1 high byte |
| cas_lat | input | 2 | Latency code, 3 gives three clocks, others give two |
| dq_out | output | 16 | Word toward the pad driver |
| dq_oe | output | 2 | Per-lane output enable |
| core_wr_data | output | 16 | Write word toward the core |
| core_wr_be | output | 2 | Per-lane core write strobe |
| lat_err | output | 1 | Latency change refused while reads were in flight |

## Verification
A read result leaving the pipeline and a masked write can occur in the same cycle. In that cycle one mask value gates the write strobes at once and also decides the output enables two cycles later. The sweeps run read-valid, write-valid and both mask bits through every combination cycle after cycle, at both latencies, so that reads in flight overlap with writes. An independent history model in the bench judges each cycle, using the mask from two edges back for the enables and the current mask for the strobes.

// File: rtl/clp_pkg.sv
package clp_pkg;
  localparam int unsigned DQ_W      = 16;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned PIPE_D    = 3;
  localparam int unsigned RMASK_LAT = 2;

  typedef enum logic [1:0] {
    LAT2 = 2'd2,
    LAT3 = 2'd3
  } lat_e;

  // code 3 gives three clocks, every other code gives two
  function automatic lat_e lat_decode(input logic [1:0] code);
    return (code == 2'd3) ? LAT3 : LAT2;
  endfunction
endpackage

// File: rtl/clp_rd_pipe.sv
// Read data delay line: valid bits shift every clock, data stages load
// only when the stage feeding them holds valid data.
module clp_rd_pipe #(
  parameter int unsigned W     = 16,
  parameter int unsigned D     = 3,
  localparam int unsigned IDX_W = (D > 1) ? $clog2(D) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [W-1:0]     in_data,
  input  logic [IDX_W-1:0] tap_idx,
  output logic             tap_vld,
  output logic [W-1:0]     tap_data,
  output logic             busy
);
  logic [D-1:0]        vld_q, vld_d;
  logic [D-1:0][W-1:0] dat_q, dat_d;
  logic [D-1:0]        ld_en;

  always_comb begin
    vld_d    = {vld_q[D-2:0], in_vld};
    ld_en[0] = in_vld;
    dat_d[0] = in_data;
    for (int i = 1; i < D; i++) begin
      ld_en[i] = vld_q[i-1];
      dat_d[i] = dat_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < D; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dat_q[g] <= '0;
      else if (ld_en[g]) dat_q[g] <= dat_d[g];
    end
  end

  always_comb begin
    tap_vld  = 1'b0;
    tap_data = '0;
    for (int i = 0; i < D; i++) begin
      if (tap_idx == IDX_W'(i)) begin
        tap_vld  = vld_q[i];
        tap_data = vld_q[i] ? dat_q[i] : '0;
      end
    end
  end

  assign busy = in_vld | (|vld_q);
endmodule

// File: rtl/clp_mask_dly.sv
// Fixed-depth delay of the lane masks for the read output enables.
module clp_mask_dly #(
  parameter int unsigned N   = 2,
  parameter int unsigned LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] mask_in,
  output logic [N-1:0] mask_out
);
  logic [LAT-1:0][N-1:0] stg_q, stg_d;

  always_comb begin
    stg_d[0] = mask_in;
    for (int i = 1; i < LAT; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign mask_out = stg_q[LAT-1];
endmodule

// File: rtl/clp_lat_ctl.sv
// Holds the active latency; refuses a change while reads are pending.
module clp_lat_ctl
  import clp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cas_code,
  input  logic       busy,
  output lat_e       lat_q,
  output logic       lat_err
);
  lat_e req;
  logic differs, upd_en, err_d;

  always_comb begin
    req     = lat_decode(cas_code);
    differs = (req != lat_q);
    upd_en  = differs & ~busy;
    err_d   = differs & busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= LAT3;
      lat_err <= 1'b0;
    end else begin
      if (upd_en) lat_q <= req;
      lat_err <= err_d;
    end
  end
endmodule

// File: rtl/clp_wr_mask.sv
// Same-cycle write lane gating.
module clp_wr_mask #(
  parameter int unsigned N  = 2,
  parameter int unsigned LW = 8
) (
  input  logic            wr_vld,
  input  logic [N-1:0]    mask,
  input  logic [N*LW-1:0] wdata_in,
  output logic [N-1:0]    be,
  output logic [N*LW-1:0] wdata_out
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign be[g] = wr_vld & ~mask[g];
  end
  assign wdata_out = wdata_in;
endmodule

// File: rtl/cl_read_pipe.sv
module cl_read_pipe
  import clp_pkg::*;
#(
  parameter int unsigned DATA_W = clp_pkg::DQ_W,
  parameter int unsigned BYTE_W = clp_pkg::LANE_W,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned TAP_W = $clog2(PIPE_D)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  byte_mask,
  input  logic [1:0]        cas_lat,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe,
  output logic [DATA_W-1:0] core_wr_data,
  output logic [LANES-1:0]  core_wr_be,
  output logic              lat_err
);
  lat_e             lat_q;
  logic             busy;
  logic             tap_vld;
  logic [TAP_W-1:0] tap_idx;
  logic [LANES-1:0] rmask;

  // latency L reads stage L-1
  assign tap_idx = (lat_q == LAT3) ? TAP_W'(2) : TAP_W'(1);

  clp_lat_ctl u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas_code (cas_lat),
    .busy     (busy),
    .lat_q    (lat_q),
    .lat_err  (lat_err)
  );

  clp_rd_pipe #(.W(DATA_W), .D(PIPE_D)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (rd_vld),
    .in_data  (rd_data),
    .tap_idx  (tap_idx),
    .tap_vld  (tap_vld),
    .tap_data (dq_out),
    .busy     (busy)
  );

  clp_mask_dly #(.N(LANES), .LAT(RMASK_LAT)) u_mdly (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_in  (byte_mask),
    .mask_out (rmask)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_oe
    assign dq_oe[g] = tap_vld & ~rmask[g];
  end

  clp_wr_mask #(.N(LANES), .LW(BYTE_W)) u_wr (
    .wr_vld    (wr_vld),
    .mask      (byte_mask),
    .wdata_in  (wr_data),
    .be        (core_wr_be),
    .wdata_out (core_wr_data)
  );
endmodule

// File: rtl/clp_chk.sv
module clp_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_vld,
  input logic              wr_vld,
  input logic [LANES-1:0]  byte_mask,
  input logic [DATA_W-1:0] dq_out,
  input logic [LANES-1:0]  dq_oe,
  input logic [LANES-1:0]  core_wr_be,
  input logic              lat_err
);
  assert_wrbe_needs_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_wr_be) |-> wr_vld);

  assert_wrbe_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_be & byte_mask) == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assert_oe_mask_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe[g] |-> !$past(byte_mask[g], 2));
  end

  assert_oe_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> ($past(rd_vld, 2) || $past(rd_vld, 3)));

  assert_out_from_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_out != '0) |-> ($past(rd_vld, 2) || $past(rd_vld, 3)));

  assert_err_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lat_err |-> ($past(rd_vld, 1) || $past(rd_vld, 2) ||
                 $past(rd_vld, 3) || $past(rd_vld, 4)));
endmodule

bind cl_read_pipe clp_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_cl_read_pipe.sv
`timescale 1ns/1ps
module sim_cl_read_pipe;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_vld, wr_vld;
  logic [15:0] rd_data, wr_data;
  logic [1:0]  byte_mask, cas_lat;
  logic [15:0] dq_out, core_wr_data;
  logic [1:0]  dq_oe, core_wr_be;
  logic        lat_err;

  always #4 clk = ~clk;

  cl_read_pipe u0 (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_data(rd_data),
    .wr_vld(wr_vld), .wr_data(wr_data), .byte_mask(byte_mask),
    .cas_lat(cas_lat), .dq_out(dq_out), .dq_oe(dq_oe),
    .core_wr_data(core_wr_data), .core_wr_be(core_wr_be), .lat_err(lat_err)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int cl_m = 3;
  logic exp_err = 1'b0;
  logic        h_rd  [0:511];
  logic [15:0] h_dat [0:511];
  logic [1:0]  h_msk [0:511];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic hrd(input int i);
    return (i >= 0) ? h_rd[i] : 1'b0;
  endfunction
  function automatic logic [15:0] hdat(input int i);
    return (i >= 0) ? h_dat[i] : 16'h0;
  endfunction
  function automatic logic [1:0] hmsk(input int i);
    return (i >= 0) ? h_msk[i] : 2'b00;
  endfunction

  task automatic step(input logic r, input logic [15:0] rd, input logic w,
                      input logic [15:0] wd, input logic [1:0] m, input logic [1:0] cas);
    logic        v, busy;
    logic [1:0]  oe_e, be_e;
    logic [15:0] out_e;
    int          sel;
    @(negedge clk);
    rd_vld = r; rd_data = rd; wr_vld = w; wr_data = wd; byte_mask = m; cas_lat = cas;
    h_rd[cyc] = r; h_dat[cyc] = rd; h_msk[cyc] = m;
    #1;
    v     = hrd(cyc - cl_m);
    out_e = v ? hdat(cyc - cl_m) : 16'h0;
    oe_e  = v ? ~hmsk(cyc - 2) : 2'b00;
    be_e  = w ? ~m : 2'b00;
    chk((hrd(cyc - cl_m - 1) && v) ? "R2 R7 R9 data back-to-back" :
        (v ? "R2 R7 data" : "R3 idle data"), dq_out, out_e);
    chk(v ? "R4 lane enables" : "R5 idle enables", {14'h0, dq_oe}, {14'h0, oe_e});
    chk("R6 write strobes", {14'h0, core_wr_be}, {14'h0, be_e});
    chk("R6 write data", core_wr_data, wd);
    chk("R8 latency error", {15'h0, lat_err}, {15'h0, exp_err});
    busy = r | hrd(cyc - 1) | hrd(cyc - 2) | hrd(cyc - 3);
    sel  = (cas == 2'd3) ? 3 : 2;
    exp_err = busy && (sel != cl_m);
    if (!busy) cl_m = sel;
    cyc++;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_vld = 0; wr_vld = 0; rd_data = 0; wr_data = 0;
    byte_mask = 0; cas_lat = 2'd3;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk("R1 reset data", dq_out, 16'h0);
    chk("R1 reset enables", {14'h0, dq_oe}, 16'h0);
    chk("R1 reset error", {15'h0, lat_err}, 16'h0);
    rst_n = 1'b1;

    // R1: default latency three, sweep of all read/write/mask combinations
    for (int n = 0; n < 64; n++) begin
      logic [5:0] b;
      b = 6'(n);
      // R9: bit 4 set gives unbroken read bursts
      step(b[4] | (b[0] ^ b[2]), 16'hA5C3 ^ 16'(n * 777), b[3] | b[0],
           16'(n * 16'h1357), b[2:1] ^ {b[5], b[3]}, 2'd3);
    end
    repeat (4) step(1'b0, 16'h0, 1'b0, 16'h0, 2'b00, 2'd3);

    // R7: switch to latency two while idle
    repeat (2) step(1'b0, 16'h0, 1'b0, 16'h0, 2'b00, 2'd2);
    // R2: codes 1 and 2 both select two clocks
    for (int n = 0; n < 64; n++) begin
      logic [5:0] b;
      b = 6'(n);
      step(b[4] | (b[1] ^ b[3]), 16'h3C5A ^ 16'(n * 1237), b[2] ^ b[0],
           16'(n * 16'h2468), b[1:0] ^ {b[4], b[5]}, b[5] ? 2'd2 : 2'd1);
    end
    repeat (4) step(1'b0, 16'h0, 1'b0, 16'h0, 2'b00, 2'd2);

    // R8: ask for three clocks while reads are in flight
    for (int n = 0; n < 6; n++)
      step(1'b1, 16'h1111 * 16'(n + 1), 1'b1, 16'h0F0F, 2'(n), 2'd3);
    repeat (6) step(1'b0, 16'h0, 1'b0, 16'h0, 2'b11, 2'd3);
    for (int n = 0; n < 16; n++)
      step(n[0] | n[2], 16'hBEEF ^ 16'(n), n[1], 16'(n), 2'(n >> 1), 2'd3);
    repeat (4) step(1'b0, 16'h0, 1'b0, 16'h0, 2'b00, 2'd3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule